// File: doc/BRIEF.md
# Serial Keypad Scan Reader

This block reads the key state of a display-and-keypad controller over its three-wire serial bus. The bus has a strobe, a clock and one bidirectional data line. A transaction starts on a one-cycle `start` pulse, or on a free-running poll timer while `poll_en` is high. The block lowers the strobe and shifts out the read-keys command byte 0x42 least significant bit first. It then stops driving the data line and waits a turnaround with the bus clock held high. It clocks in 32 response bits, which are four status bytes, and raises the strobe again. At the end it presents the raw word, an eight-key decoded vector and a one-cycle `done` pulse.

The sequencer has seven states:
- ST_IDLE: the bus is at rest.
- ST_LEAD: the strobe is low and the clock is high, as a setup half-period.
- ST_CMD_LO and ST_CMD_HI: a command bit is driven while the clock is low, then held through the rising edge.
- ST_TURN: the data driver is off and the clock is high.
- ST_RD_LO and ST_RD_HI: a response bit is sampled as the clock rises.

Every state change happens on a divider tick, which comes once every `HALF_DIV` system clocks. The one exception is the launch from ST_IDLE. The transitions are:
- ST_IDLE→ST_LEAD on a launch.
- ST_LEAD→ST_CMD_LO.
- ST_CMD_LO→ST_CMD_HI.
- ST_CMD_HI→ST_CMD_LO while command bits remain, or →ST_TURN after the eighth bit.
- ST_TURN→ST_RD_LO after `TURN_HALVES` ticks.
- ST_RD_LO→ST_RD_HI.
- ST_RD_HI→ST_RD_LO while response bits remain, or →ST_IDLE after the 32nd bit.

Top module: `kp_scan_reader`

## Requirements
- R1: After a synchronous reset, `bus_stb`, `bus_clk` and `bus_dout` are high, and `bus_oe`, `busy` and `done` are low. Whenever the block is idle, the strobe and clock are high and the output enable is low.
- R2: A `start` pulse while idle lowers the strobe and raises `busy` on the next cycle. A `start` pulse while busy is ignored and launches no second frame.
- R3: The first byte shifted out after the strobe falls is 0x42, least significant bit first. `bus_dout` changes only while `bus_clk` is low.
- R4: The bus clock idles high, goes low only inside a frame, and each low half-period lasts exactly `HALF_DIV` system clocks (default 8).
- R5: After the eighth command bit, `bus_oe` falls. `bus_oe` is high only while the strobe is low. The clock then stays high for `TURN_HALVES` half-periods (default 2) before the first read falling edge.
- R6: Exactly 32 response bits are captured on rising bus-clock edges. The first bit received becomes `raw_word[0]`, so byte k of the response is `raw_word[8k+7:8k]`.
- R7: The strobe stays low for the whole frame, which contains exactly 40 rising clock edges: 8 for the command and 32 for the response. The strobe rises at the end of the frame.
- R8: `done` is high for exactly one system clock, in the cycle in which the strobe rises and `busy` falls. `raw_word` holds the new value from that cycle onward.
- R9: Key n of `keys` is `raw_word` bit 1 of byte n/2 for even n, and bit 5 of byte n/2 for odd n. A response whose first byte is 0x02 and whose other bytes are zero sets only key 0.
- R10: While `poll_en` is high and the block is idle, a frame launches after `POLL_CYCLES` idle cycles. While `poll_en` is low, no frame launches without `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to launch a scan |
| poll_en | input | 1 | Enables the periodic poll timer |
| bus_stb | output | 1 | Frame strobe, active low |
| bus_clk | output | 1 | Serial bus clock, idles high |
| bus_dout | output | 1 | Data driven toward the controller |
| bus_oe | output | 1 | Output enable for the shared data pad |
| bus_din | input | 1 | Data read from the shared data pad |
| raw_word | output | 32 | Last four response bytes, first byte in bits 7:0 |
| keys | output | 8 | Decoded pressed-key vector |
| done | output | 1 | One-cycle pulse when a scan completes |
| busy | output | 1 | High while a frame is in progress |

## Verification
A behavioural controller model on the bench decodes the command from the bus pins and returns a chosen response word bit by bit on falling clock edges. Response words of all zeros, all ones, only the leftmost key, every key bit set, and every bit set except the key bits show whether the bit order and the key map pick the right positions. Seeded random words cover the remaining bit patterns. Extra start pulses in mid-frame, and idle periods with the poll timer on and off, tell an ignored request apart from a relaunch.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_TURN,
        ST_RD_LO,
        ST_RD_HI
    } kp_state_t;

    localparam logic [7:0] CMD_READ_KEYS = 8'h42;
    localparam int CMD_BITS  = 8;
    localparam int RESP_BITS = 32;
    localparam int NUM_KEYS  = 8;
endpackage

// File: rtl/kp_clkdiv.sv
module kp_clkdiv #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kp_keymap.sv
module kp_keymap #(
    parameter int NKEYS = 8
) (
    input  logic [4*NKEYS-1:0] raw,
    output logic [NKEYS-1:0]   keys
);
    for (genvar n = 0; n < NKEYS; n++) begin : g_key
        localparam int POS = (n / 2) * 8 + (((n % 2) == 1) ? 5 : 1);
        assign keys[n] = raw[POS];
    end
endmodule

// File: rtl/kp_scan_reader.sv
module kp_scan_reader
    import kp_pkg::*;
#(
    parameter int HALF_DIV    = 8,
    parameter int TURN_HALVES = 2,
    parameter int POLL_CYCLES = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        poll_en,
    output logic        bus_stb,
    output logic        bus_clk,
    output logic        bus_dout,
    output logic        bus_oe,
    input  logic        bus_din,
    output logic [31:0] raw_word,
    output logic [7:0]  keys,
    output logic        done,
    output logic        busy
);
    localparam int TW = $clog2(TURN_HALVES + 1);
    localparam int PW = $clog2(POLL_CYCLES + 1);
    localparam int BW = $clog2(RESP_BITS);
    localparam logic [TW-1:0] TURN_LAST = TW'(TURN_HALVES - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_CYCLES - 1);
    localparam logic [BW-1:0] CMD_LAST  = BW'(CMD_BITS - 1);
    localparam logic [BW-1:0] RESP_LAST = BW'(RESP_BITS - 1);

    kp_state_t state, state_nx;
    logic [7:0]           tx_sh;
    logic [RESP_BITS-1:0] rx_sh;
    logic [BW-1:0]        bit_cnt;
    logic [TW-1:0]        turn_cnt;
    logic [PW-1:0]        poll_cnt;
    logic                 tick, din_s, poll_fire, launch;

    kp_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .run (state != ST_IDLE),
        .tick(tick)
    );

    kp_sync #(.STAGES(2)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (bus_din),
        .q  (din_s)
    );

    kp_keymap #(.NKEYS(NUM_KEYS)) u_map (
        .raw (raw_word),
        .keys(keys)
    );

    // poll timer: counts only while idle and enabled
    assign poll_fire = poll_en && (state == ST_IDLE) && (poll_cnt == POLL_LAST);
    assign launch    = start || poll_fire;

    always_ff @(posedge clk) begin
        if (rst || !poll_en || state != ST_IDLE || poll_cnt == POLL_LAST) begin
            poll_cnt <= '0;
        end else begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (launch) state_nx = ST_LEAD;
            ST_LEAD:   if (tick) state_nx = ST_CMD_LO;
            ST_CMD_LO: if (tick) state_nx = ST_CMD_HI;
            ST_CMD_HI: if (tick) state_nx = (bit_cnt == CMD_LAST) ? ST_TURN : ST_CMD_LO;
            ST_TURN:   if (tick && turn_cnt == TURN_LAST) state_nx = ST_RD_LO;
            ST_RD_LO:  if (tick) state_nx = ST_RD_HI;
            ST_RD_HI:  if (tick) state_nx = (bit_cnt == RESP_LAST) ? ST_IDLE : ST_RD_LO;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh    <= '1;
            rx_sh    <= '0;
            bit_cnt  <= '0;
            turn_cnt <= '0;
            raw_word <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    tx_sh   <= CMD_READ_KEYS;
                    bit_cnt <= '0;
                end
                ST_CMD_HI: if (tick) begin
                    if (bit_cnt == CMD_LAST) begin
                        bit_cnt  <= '0;
                        turn_cnt <= '0;
                    end else begin
                        tx_sh   <= {1'b1, tx_sh[7:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TURN: if (tick) turn_cnt <= turn_cnt + 1'b1;
                ST_RD_LO: if (tick) rx_sh <= {din_s, rx_sh[RESP_BITS-1:1]};
                ST_RD_HI: if (tick) begin
                    if (bit_cnt == RESP_LAST) begin
                        raw_word <= rx_sh;
                        done     <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // pin outputs decoded from state
    always_comb begin
        bus_stb  = 1'b0;
        bus_clk  = 1'b1;
        bus_dout = 1'b1;
        bus_oe   = 1'b0;
        unique case (state)
            ST_IDLE:   bus_stb = 1'b1;
            ST_LEAD:   begin bus_oe = 1'b1; bus_dout = tx_sh[0]; end
            ST_CMD_LO: begin bus_oe = 1'b1; bus_dout = tx_sh[0]; bus_clk = 1'b0; end
            ST_CMD_HI: begin bus_oe = 1'b1; bus_dout = tx_sh[0]; end
            ST_TURN:   ;
            ST_RD_LO:  bus_clk = 1'b0;
            ST_RD_HI:  ;
            default:   bus_stb = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/kp_scan_checker.sv
module kp_scan_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        bus_stb,
    input logic        bus_clk,
    input logic        bus_dout,
    input logic        bus_oe,
    input logic [31:0] raw_word,
    input logic [7:0]  keys,
    input logic        done,
    input logic        busy
);
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_stb && bus_clk && !bus_oe));

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !bus_stb));

    p_dout_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && bus_clk && $past(bus_clk) && $past(bus_oe)) |-> $stable(bus_dout));

    p_clk_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_clk |-> !bus_stb);

    p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !bus_stb);

    p_stb_close_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_stb) |-> (done && !busy));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_key_map_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (keys[0] == raw_word[1] && keys[7] == raw_word[29]));
endmodule

bind kp_scan_reader kp_scan_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .bus_stb (bus_stb),
    .bus_clk (bus_clk),
    .bus_dout(bus_dout),
    .bus_oe  (bus_oe),
    .raw_word(raw_word),
    .keys    (keys),
    .done    (done),
    .busy    (busy)
);

// File: tb/tb_kp_scan_reader.sv
module tb_kp_scan_reader;
    localparam int HALF = 8;
    localparam int TURN = 2;
    localparam int POLL = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic poll_en = 1'b0;
    logic bus_din = 1'b1;
    logic bus_stb, bus_clk, bus_dout, bus_oe, done, busy;
    logic [31:0] raw_word;
    logic [7:0] keys;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    kp_scan_reader #(.HALF_DIV(HALF), .TURN_HALVES(TURN), .POLL_CYCLES(POLL)) dut (
        .clk(clk), .rst(rst), .start(start), .poll_en(poll_en),
        .bus_stb(bus_stb), .bus_clk(bus_clk), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .raw_word(raw_word),
        .keys(keys), .done(done), .busy(busy)
    );

    // controller model
    logic [31:0] resp = '0;
    logic [7:0]  cmd_rx;
    int cmd_n, rd_n, rise_n;

    always @(negedge bus_stb) begin
        cmd_n = 0; rd_n = 0; rise_n = 0; cmd_rx = '0;
    end
    always @(posedge bus_clk) if (!bus_stb) begin
        rise_n++;
        if (bus_oe && cmd_n < 8) begin cmd_rx[cmd_n] = bus_dout; cmd_n++; end
    end
    always @(negedge bus_clk) if (!bus_stb && cmd_n == 8 && !bus_oe && rd_n < 32) begin
        bus_din = resp[rd_n]; rd_n++;
    end

    // pin timing monitor, sampled on falling system edges
    int frames = 0, low_run = 0, low_min = 1000, low_max = 0, gap = 0, gap_last = 0;
    bit prev_stb = 1'b1, gap_done = 1'b0;
    always @(negedge clk) begin
        if (prev_stb && !bus_stb) begin frames++; gap = 0; gap_done = 0; end
        prev_stb = bus_stb;
        if (!bus_stb && !bus_clk) low_run++;
        else if (low_run != 0) begin
            if (low_run < low_min) low_min = low_run;
            if (low_run > low_max) low_max = low_run;
            low_run = 0;
        end
        if (!bus_stb && !bus_oe && !gap_done) begin
            if (bus_clk) gap++;
            else begin gap_done = 1; gap_last = gap; end
        end
    end

    function automatic logic [7:0] exp_keys(input logic [31:0] w);
        logic [7:0] k;
        for (int n = 0; n < 8; n++) k[n] = w[(n / 2) * 8 + ((n % 2 == 1) ? 5 : 1)];
        return k;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] w, input bit extra_start);
        int f0;
        int t;
        f0 = frames;
        resp = w;
        pulse_start();
        chk(busy && !bus_stb, "R2 launch", {30'd0, busy, bus_stb}, 32'd2);
        if (extra_start) begin
            repeat (100) @(negedge clk);
            pulse_start();
        end
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R8 done seen", {31'd0, done}, 32'd1);
        chk(bus_stb && !busy, "R7 strobe closes", {30'd0, bus_stb, busy}, 32'd2);
        chk(cmd_rx == 8'h42, "R3 command byte", {24'd0, cmd_rx}, 32'h42);
        chk(rise_n == 40, "R7 rising edges", rise_n, 40);
        chk(raw_word == w, "R6 raw word", raw_word, w);
        chk(keys == exp_keys(w), "R9 keys", {24'd0, keys}, {24'd0, exp_keys(w)});
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
        chk(raw_word == w, "R8 raw held", raw_word, w);
        repeat (20) @(negedge clk);
        chk(frames == f0 + 1, "R2 start while busy ignored", frames, f0 + 1);
    endtask

    initial begin
        int f0;
        process::self().srandom(32'd1638);
        repeat (3) @(negedge clk);
        chk(bus_stb && bus_clk && bus_dout && !bus_oe && !busy && !done, "R1 reset pins",
            {26'd0, bus_stb, bus_clk, bus_dout, bus_oe, busy, done}, 32'h38);
        @(negedge clk); rst = 1'b0;
        repeat (5) @(negedge clk);

        run_frame(32'h0000_0000, 1'b0);
        run_frame(32'h0000_0002, 1'b1);
        chk(keys == 8'h01, "R9 leftmost key only", {24'd0, keys}, 32'h01);
        run_frame(32'hFFFF_FFFF, 1'b0);
        run_frame(32'h2222_2222, 1'b1);
        run_frame(32'hDDDD_DDDD, 1'b0);
        for (int i = 0; i < 6; i++) run_frame($urandom, (i % 2) == 1);

        chk(low_min == HALF && low_max == HALF, "R4 low half-period", low_min, HALF);
        chk(gap_last == TURN * HALF, "R5 turnaround", gap_last, TURN * HALF);

        f0 = frames;
        repeat (1000) @(negedge clk);
        chk(frames == f0, "R10 no poll when disabled", frames, f0);
        resp = 32'h0000_0200;
        poll_en = 1'b1;
        repeat (2500) @(negedge clk);
        poll_en = 1'b0;
        chk(frames >= f0 + 2, "R10 poll launches", frames, f0 + 2);
        repeat (1000) @(negedge clk);
        chk(raw_word == 32'h0000_0200 && keys == 8'h04, "R10 poll result",
            raw_word, 32'h0000_0200);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule